// File: doc/BRIEF.md
# Accumulator increment, decrement and rotate flag unit

This unit is the small arithmetic slice of an 8-bit accumulator processor that handles single-step increment and decrement, the two left rotates of the accumulator, and the transfer of accumulator plus flags to and from a 16-bit stack word. One operation is presented with a strobe. A cycle later the unit returns the new 8-bit value, the complete updated flag byte and a one-cycle done pulse.

The flag byte follows one processor family's rules exactly, including the undocumented copies of result bits 5 and 3. Increment and decrement never touch carry. The rotates never touch sign, zero or parity/overflow. The flag byte layout is, from bit 7 down to bit 0: sign (S), zero (Z), copy of bit 5 (Y), half carry (H), copy of bit 3 (X), parity/overflow (V), subtract (N), carry (C).

Operation codes on `op_i`: 0 increment, 1 decrement, 2 rotate left through carry, 3 rotate left circular, 4 pack, 5 unpack. Codes 6 and 7 pass the operand and flags through unchanged.

Top module: `acc_flag_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `flags_o` and `word_o` are zero and `done_o` is low.
- R2: A high `valid_i` at a rising edge updates `result_o` and `flags_o` and raises `done_o` for that edge's following cycle only. When `valid_i` is low, `done_o` goes low and both outputs hold their values.
- R3: Increment (op 0) gives operand+1 modulo 256. S is result bit 7, Z is set when the result is 0, and Y and X (flag bits 5 and 3) copy result bits 5 and 3. Decrement uses the same four rules.
- R4: Increment sets H (flag bit 4) exactly when the operand's low nibble is 0xF. It sets V (flag bit 2) only for operand 0x7F, and it clears N (flag bit 1).
- R5: Decrement (op 1) gives operand-1 modulo 256. It sets H exactly when the operand's low nibble is 0x0, sets V only for operand 0x80, and sets N.
- R6: Increment and decrement copy the incoming carry (flag bit 0) to the output unchanged.
- R7: Rotate left through carry (op 2) puts operand bit 7 into C and the incoming C into result bit 0. The other bits shift up by one.
- R8: Rotate left circular (op 3) puts operand bit 7 into both C and result bit 0. The incoming C has no effect on the result.
- R9: Both rotates clear H and N, copy Y and X from the new result, and keep the incoming S, Z and V.
- R10: `word_o` always equals {`result_o`, `flags_o`}. Pack (op 4) loads the operand as result and the incoming flags as flags. Unpack (op 5) loads `word_i[15:8]` as result and `word_i[7:0]` as flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| operand_i | input | 8 | Operand or accumulator value |
| flags_i | input | 8 | Current flag byte |
| word_i | input | 16 | Stack word for unpack |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered flag byte |
| word_o | output | 16 | Registered result and flags as a stack word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `valid_i` stays low while reset is asserted and for the first edge after release, so every `$past` sample they use comes after reset. They also assume that `op_i`, `operand_i` and `flags_i` are known whenever `valid_i` is high. The bench meets these conditions by changing inputs only on falling edges, holding `valid_i` low through and just after reset, and raising it for a single cycle per operation. All operands and flag bytes it applies are fully defined.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef enum logic [2:0] {
    OP_INC    = 3'd0,
    OP_DEC    = 3'd1,
    OP_RLA    = 3'd2,
    OP_RLCA   = 3'd3,
    OP_PACK   = 3'd4,
    OP_UNPACK = 3'd5
  } afu_op_e;

  localparam int FLAG_W = 8;
  localparam int FS = 7;
  localparam int FZ = 6;
  localparam int FY = 5;
  localparam int FH = 4;
  localparam int FX = 3;
  localparam int FV = 2;
  localparam int FN = 1;
  localparam int FC = 0;
endpackage

// File: rtl/afu_incdec.sv
module afu_incdec
  import afu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              dec_i,
  input  logic [DW-1:0]     a_i,
  input  logic [FLAG_W-1:0] f_i,
  output logic [DW-1:0]     r_o,
  output logic [FLAG_W-1:0] f_o
);
  localparam logic [DW-1:0] ONE     = DW'(1);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

  logic half, ovf;

  always_comb begin
    r_o  = dec_i ? (a_i - ONE) : (a_i + ONE);
    half = dec_i ? (a_i[3:0] == 4'h0) : (a_i[3:0] == 4'hF);
    ovf  = dec_i ? (a_i == MIN_NEG) : (a_i == MAX_POS);
    f_o     = '0;
    f_o[FS] = r_o[DW-1];
    f_o[FZ] = (r_o == '0);
    f_o[FY] = r_o[5];
    f_o[FH] = half;
    f_o[FX] = r_o[3];
    f_o[FV] = ovf;
    f_o[FN] = dec_i;
    f_o[FC] = f_i[FC];  // carry untouched
  end
endmodule

// File: rtl/afu_rotate.sv
module afu_rotate
  import afu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              circ_i,
  input  logic [DW-1:0]     a_i,
  input  logic [FLAG_W-1:0] f_i,
  output logic [DW-1:0]     r_o,
  output logic [FLAG_W-1:0] f_o
);
  logic fill;

  always_comb begin
    fill    = circ_i ? a_i[DW-1] : f_i[FC];
    r_o     = {a_i[DW-2:0], fill};
    f_o     = f_i;  // S, Z, V kept
    f_o[FY] = r_o[5];
    f_o[FH] = 1'b0;
    f_o[FX] = r_o[3];
    f_o[FN] = 1'b0;
    f_o[FC] = a_i[DW-1];
  end
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import afu_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = DW + FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DW-1:0]     operand_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [WW-1:0]     word_i,
  output logic [DW-1:0]     result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [WW-1:0]     word_o,
  output logic              done_o
);
  logic [DW-1:0]     id_r, rot_r, res_d, res_q;
  logic [FLAG_W-1:0] id_f, rot_f, flg_d, flg_q;
  logic              done_q;

  afu_incdec #(.DW(DW)) u_incdec (
    .dec_i (op_i == OP_DEC),
    .a_i   (operand_i),
    .f_i   (flags_i),
    .r_o   (id_r),
    .f_o   (id_f)
  );

  afu_rotate #(.DW(DW)) u_rotate (
    .circ_i(op_i == OP_RLCA),
    .a_i   (operand_i),
    .f_i   (flags_i),
    .r_o   (rot_r),
    .f_o   (rot_f)
  );

  always_comb begin
    res_d = operand_i;
    flg_d = flags_i;
    case (op_i)
      OP_INC, OP_DEC: begin
        res_d = id_r;
        flg_d = id_f;
      end
      OP_RLA, OP_RLCA: begin
        res_d = rot_r;
        flg_d = rot_f;
      end
      OP_UNPACK: begin
        res_d = word_i[WW-1:FLAG_W];
        flg_d = word_i[FLAG_W-1:0];
      end
      default: ;  // pack and spare codes pass through
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign result_o = res_q;
  assign flags_o  = flg_q;
  assign word_o   = {res_q, flg_q};
  assign done_o   = done_q;
endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DW-1:0]     operand_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DW-1:0]     result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              done_o
);
  logic is_id, is_rot;
  assign is_id  = valid_i && (op_i == OP_INC || op_i == OP_DEC);
  assign is_rot = valid_i && (op_i == OP_RLA || op_i == OP_RLCA);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);  // R2
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o));  // R2
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_id |=> flags_o[FZ] == (result_o == '0));  // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_INC && operand_i != 8'h7F |=> !flags_o[FV]);  // R4
  AST_SUB_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_DEC |=> flags_o[FN]);  // R5
  AST_CARRY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_id |=> flags_o[FC] == $past(flags_i[FC]));  // R6
  AST_RLC_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_RLCA |=> result_o[0] == flags_o[FC]);  // R8
  AST_ROT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rot |=> flags_o[FS] == $past(flags_i[FS]) && flags_o[FZ] == $past(flags_i[FZ])
               && flags_o[FV] == $past(flags_i[FV]) && !flags_o[FH] && !flags_o[FN]);  // R9
endmodule

bind acc_flag_unit afu_checker #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .operand_i(operand_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .flags_o  (flags_o),
  .done_o   (done_o)
);

// File: tb/sim_acc_flag_unit.sv
module sim_acc_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {op[2:0], operand, flags_in, exp_result, exp_flags}
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 8'h00, 8'h00, 8'h01, 8'h00},  // R3
    {3'd0, 8'h0F, 8'h01, 8'h10, 8'h11},  // R4 R6
    {3'd0, 8'h7F, 8'h00, 8'h80, 8'h94},  // R4
    {3'd0, 8'hFF, 8'h00, 8'h00, 8'h50},  // R3
    {3'd0, 8'h27, 8'hFF, 8'h28, 8'h29},  // R3 R6
    {3'd1, 8'h01, 8'h00, 8'h00, 8'h42},  // R5
    {3'd1, 8'h80, 8'h00, 8'h7F, 8'h3E},  // R5
    {3'd1, 8'h00, 8'h01, 8'hFF, 8'hBB},  // R5 R6
    {3'd2, 8'h81, 8'h00, 8'h02, 8'h01},  // R7
    {3'd2, 8'h81, 8'h01, 8'h03, 8'h01},  // R7
    {3'd2, 8'h14, 8'hD6, 8'h28, 8'hEC},  // R9
    {3'd3, 8'h81, 8'h00, 8'h03, 8'h01},  // R8
    {3'd3, 8'h14, 8'h01, 8'h28, 8'h28},  // R8
    {3'd3, 8'h80, 8'hFF, 8'h01, 8'hC5}   // R9
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [7:0]  operand_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] word_i = '0;
  logic [7:0]  result_o, flags_o;
  logic [15:0] word_o;
  logic        done_o;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_flag_unit u0 (
    .clk_i, .rst_ni, .valid_i, .op_i, .operand_i, .flags_i, .word_i,
    .result_o, .flags_o, .word_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f, input logic [15:0] w);
    @(negedge clk_i);
    op_i = op; operand_i = a; flags_i = f; word_i = w; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(result_o == 8'h00, "R1 result", {8'h0, result_o}, 16'h0);
    chk(flags_o == 8'h00, "R1 flags", {8'h0, flags_o}, 16'h0);
    chk(word_o == 16'h0 && !done_o, "R1 word/done", word_o, 16'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34:32], VEC[i][31:24], VEC[i][23:16], 16'h0);
      chk(result_o == VEC[i][15:8], $sformatf("R3-R9 vec%0d result", i), {8'h0, result_o}, {8'h0, VEC[i][15:8]});
      chk(flags_o == VEC[i][7:0], $sformatf("R3-R9 vec%0d flags", i), {8'h0, flags_o}, {8'h0, VEC[i][7:0]});
      chk(done_o, "R2 done high", {15'h0, done_o}, 16'h1);
    end

    // R2: idle cycle holds outputs and drops done
    operand_i = 8'h55; flags_i = 8'hAA; op_i = 3'd0;
    @(negedge clk_i);
    chk(!done_o, "R2 done low", {15'h0, done_o}, 16'h0);
    chk(result_o == 8'h01 && flags_o == 8'hC5, "R2 hold", {result_o, flags_o}, 16'h01C5);

    // R10 pack
    apply(3'd4, 8'hA5, 8'h3C, 16'hFFFF);
    chk(word_o == 16'hA53C, "R10 pack", word_o, 16'hA53C);
    // R10 unpack
    apply(3'd5, 8'h11, 8'h22, 16'h5AC3);
    chk(result_o == 8'h5A && flags_o == 8'hC3, "R10 unpack", {result_o, flags_o}, 16'h5AC3);
    chk(word_o == 16'h5AC3, "R10 word", word_o, 16'h5AC3);

    // R1 asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1 chk(word_o == 16'h0 && !done_o, "R1 async reset", word_o, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule